// File: doc/BRIEF.md
# Power State Controller with Battery Monitor

This block decides which power state a contactless front-end chip is in and drives the domain switches that follow from it. It runs on the always-on slow clock. It watches the chip enable level, a flag saying the pad supply is present, a battery comparator output, and three wake sources: a host-address match, RF field detection and a wake timer. From these it selects one of four power states: Hard Power Down, Monitor, Standby and Active. While Active and out of reset, it also tracks one of three operating sub-modes: Idle, Listener and Poller.

The battery comparator is analog and outside the block. The block tells it which threshold to use: the lower or upper critical level, raised by the hysteresis margin while the chip sits in Monitor. The block filters the comparator result before acting on it. Every entry into Active powers the core domain first and the CPU domain one cycle later. The core reset is released a fixed number of cycles after entry. With autonomous standby enabled, a long enough stretch in Idle drops the chip into Standby, where only the always-on logic stays powered.

Top module: `pwr_state_ctrl`

## Requirements
- R1: `pwrState` encodes 0 = Hard Power Down, 1 = Monitor, 2 = Standby, 3 = Active. While `rstN` is low, the state is Hard Power Down, both domains are off, `coreRstN` is low and `subMode` is 0.
- R2: If `enPin` or `supplyOk` is low at a clock edge, the state after that edge is Hard Power Down, whatever the other inputs are. In Hard Power Down both domains are off and `coreRstN` is low.
- R3: From Hard Power Down with `enPin` and `supplyOk` both high, the next state is Active.
- R4: `thrSel[1]` follows `cfgThrHigh` (0 = lower 2.3 V level, 1 = upper 2.75 V level). `thrSel[0]` is 1 exactly while the state is Monitor, which asks the comparator for the level plus the hysteresis margin of about 150 mV.
- R5: The block acts on a change of `battAboveCmp` only after the new level has been held for DEB_LEN consecutive edges (default 4). A shorter excursion has no effect on the state.
- R6: When the monitor is armed and `cfgMonEn` is 1, a filtered "below" level moves Active or Standby to Monitor. Monitor moves to Active once the filtered level reads "above" against the raised threshold, or once `cfgMonEn` is cleared. Enable and supply loss take priority over Monitor, and Monitor takes priority over wake and autonomous standby.
- R7: The monitor is disarmed in Hard Power Down. It arms on the first edge after `coreRstN` has been released, so a low battery during boot has no effect.
- R8: In Standby both domains are off and `coreRstN` is low. Standby moves to Active when any of `wakeAddr`, `wakeRf` or `wakeTimer` is high, and stays in Standby otherwise.
- R9: On every entry to Active, `coreOn` rises with the state change, `cpuOn` rises one cycle later, and `coreRstN` rises SETTLE_CYC (default 4) cycles after entry.
- R10: `modeReq` encodes 0 = Idle, 1 = Listener, 2 = Poller. While Active with `coreRstN` high, `subMode` takes the requested value on the next edge. The value 3 is ignored and the previous sub-mode is kept. Outside released Active, `subMode` reads 0.
- R11: With `cfgAutoStby` set, IDLE_LIM (default 16) consecutive edges in released Active with `subMode` Idle move the state to Standby. Listener or Poller prevents this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| enPin | input | 1 | Chip enable pin level |
| supplyOk | input | 1 | Pad supply present |
| battAboveCmp | input | 1 | Comparator: battery above the selected threshold |
| wakeAddr | input | 1 | Host own-address wake |
| wakeRf | input | 1 | RF field detected wake |
| wakeTimer | input | 1 | Wake timer expiry |
| modeReq | input | 2 | Requested Active sub-mode |
| cfgMonEn | input | 1 | Battery monitor enable |
| cfgThrHigh | input | 1 | Critical level select |
| cfgAutoStby | input | 1 | Autonomous standby enable |
| pwrState | output | 2 | Current power state |
| subMode | output | 2 | Current Active sub-mode |
| coreOn | output | 1 | Core domain power switch enable |
| cpuOn | output | 1 | CPU domain power switch enable |
| coreRstN | output | 1 | Reset to the core, active low |
| thrSel | output | 2 | Comparator threshold select |

## Verification
The hardest case to reach from the ports is a low battery that is already present when the chip comes out of Hard Power Down. The filter settles to "below" during the boot window, yet Monitor must wait until the monitor arms. The bench holds the comparator low across an enable pulse. It then checks that the state stays Active through the whole reset window and enters Monitor only on the second edge after `coreRstN` rises. Standby is reached through the autonomous idle timeout, so each wake source is exercised after a full settle and idle run.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_HPD  = 2'd0,
    PS_MON  = 2'd1,
    PS_STBY = 2'd2,
    PS_ACT  = 2'd3
  } pwrState_e;

  typedef enum logic [1:0] {
    SM_IDLE   = 2'd0,
    SM_LISTEN = 2'd1,
    SM_POLL   = 2'd2,
    SM_RSVD   = 2'd3
  } subMode_e;

  // control -> datapath
  typedef struct packed {
    logic settleLoad;
    logic idleRun;
    logic filtHold;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic battOk;
    logic settleZero;
    logic settleFull;
    logic idleAtLimit;
  } dpStatus_t;

endpackage

// File: rtl/pwr_dp.sv
module pwr_dp
  import pwr_pkg::*;
#(
  parameter int DEB_LEN    = 4,
  parameter int SETTLE_CYC = 4,
  parameter int IDLE_LIM   = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      battAboveCmp,
  input  dpStrobe_t strobe,
  output dpStatus_t status
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int IW = (IDLE_LIM > 1) ? $clog2(IDLE_LIM) : 1;
  localparam logic [SW-1:0] SETTLE_INIT = SW'(SETTLE_CYC);
  localparam logic [IW-1:0] IDLE_LAST   = IW'(IDLE_LIM - 1);

  logic          battFilt;
  logic [SW-1:0] settleCnt;
  logic [IW-1:0] idleCnt;

  // comparator debounce: variant chosen by filter length
  generate
    if (DEB_LEN <= 1) begin : g_noFilt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                battFilt <= 1'b1;
        else if (strobe.filtHold) battFilt <= 1'b1;
        else                      battFilt <= battAboveCmp;
      end
    end else begin : g_filt
      localparam int DW = $clog2(DEB_LEN);
      localparam logic [DW-1:0] DEB_LAST = DW'(DEB_LEN - 1);
      logic [DW-1:0] debCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          battFilt <= 1'b1;
          debCnt   <= '0;
        end else if (strobe.filtHold) begin
          battFilt <= 1'b1;
          debCnt   <= '0;
        end else if (battAboveCmp != battFilt) begin
          if (debCnt == DEB_LAST) begin
            battFilt <= battAboveCmp;
            debCnt   <= '0;
          end else begin
            debCnt <= debCnt + 1'b1;
          end
        end else begin
          debCnt <= '0;
        end
      end
    end
  endgenerate

  // power-up settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  settleCnt <= '0;
    else if (strobe.settleLoad) settleCnt <= SETTLE_INIT;
    else if (settleCnt != '0)   settleCnt <= settleCnt - 1'b1;
  end

  // idle residency counter for autonomous standby
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   idleCnt <= '0;
    else if (!strobe.idleRun)    idleCnt <= '0;
    else if (idleCnt == IDLE_LAST) idleCnt <= '0;
    else                         idleCnt <= idleCnt + 1'b1;
  end

  always_comb begin
    status.battOk      = battFilt;
    status.settleZero  = (settleCnt == '0);
    status.settleFull  = (settleCnt == SETTLE_INIT);
    status.idleAtLimit = (idleCnt == IDLE_LAST);
  end

endmodule

// File: rtl/pwr_ctl.sv
module pwr_ctl
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       supplyOk,
  input  logic       wakeAddr,
  input  logic       wakeRf,
  input  logic       wakeTimer,
  input  logic [1:0] modeReq,
  input  logic       cfgMonEn,
  input  logic       cfgThrHigh,
  input  logic       cfgAutoStby,
  input  dpStatus_t  status,
  output dpStrobe_t  strobe,
  output logic [1:0] pwrState,
  output logic [1:0] subMode,
  output logic       coreOn,
  output logic       cpuOn,
  output logic       coreRstN,
  output logic [1:0] thrSel
);

  pwrState_e stateQ, stateD;
  subMode_e  subQ, subD;
  logic      monArmed;
  logic      released, monLive, wakeAny, idleExpire, dropToMon;

  assign released   = (stateQ == PS_ACT) && status.settleZero;
  assign monLive    = monArmed && cfgMonEn;
  assign wakeAny    = wakeAddr || wakeRf || wakeTimer;
  assign dropToMon  = monLive && !status.battOk;
  assign idleExpire = strobe.idleRun && status.idleAtLimit;

  always_comb begin
    strobe.idleRun  = released && cfgAutoStby && (subQ == SM_IDLE);
    strobe.filtHold = (stateQ == PS_HPD);
  end

  always_comb begin
    stateD = stateQ;
    if (!enPin || !supplyOk) begin
      stateD = PS_HPD;
    end else begin
      unique case (stateQ)
        PS_HPD:  stateD = PS_ACT;
        PS_MON:  stateD = (status.battOk || !cfgMonEn) ? PS_ACT : PS_MON;
        PS_STBY: begin
          if (dropToMon)    stateD = PS_MON;
          else if (wakeAny) stateD = PS_ACT;
        end
        PS_ACT: begin
          if (dropToMon)       stateD = PS_MON;
          else if (idleExpire) stateD = PS_STBY;
        end
        default: stateD = PS_HPD;
      endcase
    end
  end

  always_comb strobe.settleLoad = (stateD == PS_ACT) && (stateQ != PS_ACT);

  always_comb begin
    subD = SM_IDLE;
    if (released && stateD == PS_ACT) begin
      if (modeReq == SM_RSVD) subD = subQ;
      else                    subD = subMode_e'(modeReq);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= PS_HPD;
      subQ     <= SM_IDLE;
      monArmed <= 1'b0;
    end else begin
      stateQ   <= stateD;
      subQ     <= subD;
      if (stateQ == PS_HPD) monArmed <= 1'b0;
      else if (released)    monArmed <= 1'b1;
    end
  end

  assign pwrState = stateQ;
  assign subMode  = subQ;
  assign coreOn   = (stateQ == PS_ACT);
  assign cpuOn    = (stateQ == PS_ACT) && !status.settleFull;
  assign coreRstN = released;
  assign thrSel   = {cfgThrHigh, stateQ == PS_MON};

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int DEB_LEN    = 4,
  parameter int SETTLE_CYC = 4,
  parameter int IDLE_LIM   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       supplyOk,
  input  logic       battAboveCmp,
  input  logic       wakeAddr,
  input  logic       wakeRf,
  input  logic       wakeTimer,
  input  logic [1:0] modeReq,
  input  logic       cfgMonEn,
  input  logic       cfgThrHigh,
  input  logic       cfgAutoStby,
  output logic [1:0] pwrState,
  output logic [1:0] subMode,
  output logic       coreOn,
  output logic       cpuOn,
  output logic       coreRstN,
  output logic [1:0] thrSel
);

  dpStrobe_t strobe;
  dpStatus_t status;

  pwr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .enPin(enPin), .supplyOk(supplyOk),
    .wakeAddr(wakeAddr), .wakeRf(wakeRf), .wakeTimer(wakeTimer),
    .modeReq(modeReq), .cfgMonEn(cfgMonEn), .cfgThrHigh(cfgThrHigh),
    .cfgAutoStby(cfgAutoStby), .status(status), .strobe(strobe),
    .pwrState(pwrState), .subMode(subMode), .coreOn(coreOn),
    .cpuOn(cpuOn), .coreRstN(coreRstN), .thrSel(thrSel)
  );

  pwr_dp #(
    .DEB_LEN(DEB_LEN), .SETTLE_CYC(SETTLE_CYC), .IDLE_LIM(IDLE_LIM)
  ) u_dp (
    .clk(clk), .rstN(rstN), .battAboveCmp(battAboveCmp),
    .strobe(strobe), .status(status)
  );

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       enPin,
  input logic       supplyOk,
  input logic       wakeAddr,
  input logic       wakeRf,
  input logic       wakeTimer,
  input logic       cfgMonEn,
  input logic [1:0] pwrState,
  input logic [1:0] subMode,
  input logic       coreOn,
  input logic       cpuOn,
  input logic       coreRstN,
  input logic [1:0] thrSel
);

  AST_ENABLE_LOSS_HPD: assert property (@(posedge clk) disable iff (!rstN)
    (!enPin || !supplyOk) |=> (pwrState == PS_HPD)); // R2
  AST_HPD_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_HPD) |-> (!coreOn && !cpuOn && !coreRstN)); // R2
  AST_BOOT_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (enPin && supplyOk && pwrState == PS_HPD) |=> (pwrState == PS_ACT)); // R3
  AST_MON_RAISED_THR: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_MON) |-> thrSel[0]); // R4
  AST_MON_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_MON && $past(pwrState) != PS_MON) |-> $past(cfgMonEn)); // R6
  AST_STBY_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_STBY) |-> (!coreOn && !cpuOn && !coreRstN)); // R8
  AST_STBY_EXIT_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_ACT && $past(pwrState) == PS_STBY)
      |-> $past(wakeAddr || wakeRf || wakeTimer)); // R8
  AST_CPU_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rstN)
    cpuOn |-> coreOn); // R9
  AST_RELEASE_AFTER_POWER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstN) |-> ($past(coreOn) && $past(cpuOn))); // R9
  AST_SUB_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !coreRstN |-> (subMode == SM_IDLE)); // R10
  AST_SUB_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    subMode != SM_RSVD); // R10

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .enPin(enPin), .supplyOk(supplyOk),
  .wakeAddr(wakeAddr), .wakeRf(wakeRf), .wakeTimer(wakeTimer),
  .cfgMonEn(cfgMonEn), .pwrState(pwrState), .subMode(subMode),
  .coreOn(coreOn), .cpuOn(cpuOn), .coreRstN(coreRstN), .thrSel(thrSel)
);

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;

  localparam int DEB = 4;
  localparam int SET = 4;
  localparam int IDL = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic enPin = 1'b1, supplyOk = 1'b1, battAboveCmp = 1'b1;
  logic wakeAddr = 1'b0, wakeRf = 1'b0, wakeTimer = 1'b0;
  logic [1:0] modeReq = 2'd0;
  logic cfgMonEn = 1'b0, cfgThrHigh = 1'b0, cfgAutoStby = 1'b0;
  logic [1:0] pwrState, subMode, thrSel;
  logic coreOn, cpuOn, coreRstN;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.DEB_LEN(DEB), .SETTLE_CYC(SET), .IDLE_LIM(IDL)) u_dut (
    .clk(clk), .rstN(rstN), .enPin(enPin), .supplyOk(supplyOk),
    .battAboveCmp(battAboveCmp), .wakeAddr(wakeAddr), .wakeRf(wakeRf),
    .wakeTimer(wakeTimer), .modeReq(modeReq), .cfgMonEn(cfgMonEn),
    .cfgThrHigh(cfgThrHigh), .cfgAutoStby(cfgAutoStby),
    .pwrState(pwrState), .subMode(subMode), .coreOn(coreOn),
    .cpuOn(cpuOn), .coreRstN(coreRstN), .thrSel(thrSel)
  );

  int errors = 0, checks = 0;
  string curReq = "R1";
  bit cmpOn = 0, done = 0;

  // behavioural reference: 0 HPD, 1 MON, 2 STBY, 3 ACT
  int mSt = 0, mSub = 0, mSet = 0, mIdle = 0, mDeb = 0;
  bit mFilt = 1, mArm = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int oSt, oSub, oSet, oIdle, nSt;
    bit oFilt, oArm, rel, run, expire, wake;
    if (!rstN) begin
      mSt = 0; mSub = 0; mSet = 0; mIdle = 0; mDeb = 0; mFilt = 1; mArm = 0;
    end else begin
      oSt = mSt; oSub = mSub; oSet = mSet; oIdle = mIdle; oFilt = mFilt; oArm = mArm;
      rel  = (oSt == 3) && (oSet == 0);
      wake = wakeAddr || wakeRf || wakeTimer;
      if (oSt == 0) begin mFilt = 1; mDeb = 0; end
      else if (battAboveCmp != oFilt) begin
        if (mDeb + 1 == DEB) begin mFilt = battAboveCmp; mDeb = 0; end
        else mDeb = mDeb + 1;
      end else mDeb = 0;
      run    = rel && cfgAutoStby && (oSub == 0);
      expire = run && (oIdle == IDL - 1);
      mIdle  = (!run || expire) ? 0 : oIdle + 1;
      if (!enPin || !supplyOk) nSt = 0;
      else if (oSt == 0) nSt = 3;
      else if (oSt == 1) nSt = (oFilt || !cfgMonEn) ? 3 : 1;
      else if (oArm && cfgMonEn && !oFilt) nSt = 1;
      else if (oSt == 2) nSt = wake ? 3 : 2;
      else nSt = expire ? 2 : 3;
      if (nSt == 3 && oSt != 3) mSet = SET;
      else if (oSet != 0) mSet = oSet - 1;
      if (oSt == 0) mArm = 0; else if (rel) mArm = 1;
      if (rel && nSt == 3) mSub = (modeReq == 2'd3) ? oSub : int'(modeReq);
      else mSub = 0;
      mSt = nSt;
    end
  end

  always @(negedge clk) begin
    #1;
    if (cmpOn) begin
      chk(curReq, "model pwrState", int'(pwrState), mSt);
      chk(curReq, "model subMode",  int'(subMode), mSub);
      chk(curReq, "model coreOn",   int'(coreOn), int'(mSt == 3));
      chk(curReq, "model cpuOn",    int'(cpuOn), int'(mSt == 3 && mSet != SET));
      chk(curReq, "model coreRstN", int'(coreRstN), int'(mSt == 3 && mSet == 0));
      chk(curReq, "model thrSel",   int'(thrSel), int'({cfgThrHigh, mSt == 1}));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog run did not complete");
      summary();
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1", "reset state", int'(pwrState), 0);
    chk("R1", "reset coreOn", int'(coreOn), 0);
    chk("R1", "reset coreRstN", int'(coreRstN), 0);
    chk("R1", "reset subMode", int'(subMode), 0);
    @(posedge clk); cmpOn = 1;
    tick(1);
    rstN = 1'b1; curReq = "R3";
    tick(1);
    chk("R3", "boot to Active", int'(pwrState), 3);
    chk("R9", "core on at entry", int'(coreOn), 1);
    chk("R9", "cpu off at entry", int'(cpuOn), 0);
    curReq = "R9";
    tick(1);
    chk("R9", "cpu on second cycle", int'(cpuOn), 1);
    tick(2);
    chk("R9", "reset held", int'(coreRstN), 0);
    tick(1);
    chk("R9", "reset released", int'(coreRstN), 1);

    curReq = "R10";
    modeReq = 2'd1; tick(1);
    chk("R10", "listener", int'(subMode), 1);
    modeReq = 2'd3; tick(2);
    chk("R10", "code 3 ignored", int'(subMode), 1);
    modeReq = 2'd2; tick(1);
    chk("R10", "poller", int'(subMode), 2);
    modeReq = 2'd0; tick(1);
    chk("R10", "idle", int'(subMode), 0);

    curReq = "R2";
    enPin = 1'b0; wakeRf = 1'b1; tick(1);
    chk("R2", "enable low HPD", int'(pwrState), 0);
    chk("R2", "HPD reset", int'(coreRstN), 0);
    wakeRf = 1'b0; battAboveCmp = 1'b0; cfgMonEn = 1'b1; tick(2);
    chk("R2", "HPD held", int'(pwrState), 0);

    curReq = "R7";
    enPin = 1'b1; tick(1);
    chk("R7", "entry Active", int'(pwrState), 3);
    tick(4);
    chk("R7", "low batt ignored in boot", int'(pwrState), 3);
    chk("R7", "released", int'(coreRstN), 1);
    tick(1);
    chk("R7", "arming edge", int'(pwrState), 3);
    curReq = "R6";
    tick(1);
    chk("R6", "enter Monitor", int'(pwrState), 1);
    chk("R4", "raised threshold", int'(thrSel), 1);
    cfgThrHigh = 1'b1; #0.1;
    chk("R4", "upper level", int'(thrSel), 3);

    curReq = "R5";
    battAboveCmp = 1'b1; tick(3);
    battAboveCmp = 1'b0; tick(2);
    chk("R5", "short recovery ignored", int'(pwrState), 1);
    battAboveCmp = 1'b1; tick(4);
    chk("R5", "still Monitor during filter", int'(pwrState), 1);
    curReq = "R6";
    tick(1);
    chk("R6", "Monitor exit", int'(pwrState), 3);
    chk("R4", "hysteresis off", int'(thrSel), 2);

    curReq = "R11";
    cfgAutoStby = 1'b1; tick(19);
    chk("R11", "idle not yet expired", int'(pwrState), 3);
    tick(1);
    chk("R11", "auto standby", int'(pwrState), 2);
    chk("R8", "standby dark", int'(coreOn) + int'(cpuOn) + int'(coreRstN), 0);
    curReq = "R8";
    tick(5);
    chk("R8", "no wake stays", int'(pwrState), 2);
    wakeRf = 1'b1; tick(1); wakeRf = 1'b0;
    chk("R8", "rf wake", int'(pwrState), 3);
    tick(20);
    chk("R8", "back in standby", int'(pwrState), 2);
    wakeAddr = 1'b1; tick(1); wakeAddr = 1'b0;
    chk("R8", "address wake", int'(pwrState), 3);
    tick(20);
    wakeTimer = 1'b1; tick(1); wakeTimer = 1'b0;
    chk("R8", "timer wake", int'(pwrState), 3);
    tick(20);
    chk("R8", "standby again", int'(pwrState), 2);

    curReq = "R6";
    battAboveCmp = 1'b0; tick(4);
    chk("R6", "filter before drop", int'(pwrState), 2);
    tick(1);
    chk("R6", "standby to Monitor", int'(pwrState), 1);
    cfgMonEn = 1'b0; tick(1);
    chk("R6", "disable leaves Monitor", int'(pwrState), 3);

    curReq = "R11";
    modeReq = 2'd1; tick(40);
    chk("R11", "listener blocks standby", int'(pwrState), 3);
    chk("R10", "listener held", int'(subMode), 1);

    curReq = "R2";
    supplyOk = 1'b0; wakeAddr = 1'b1; tick(1);
    chk("R2", "supply loss HPD", int'(pwrState), 0);
    chk("R2", "supply loss dark", int'(coreOn), 0);
    tick(3);

    done = 1;
    summary();
  end

endmodule